// File: doc/BRIEF.md
# Key-Protected Reset and Control Register

This block is one 32-bit control word for system-level settings. Software changes it only when the upper half of the write carries a fixed unlock value. Any other write is thrown away whole. When the upper half is read, it returns a different fixed signature rather than the stored key.

The word holds a 3-bit priority-group field. It also reports the data byte order, which is latched from an input pin while reset is held. Three action bits cause effects outside the block:
- A local system reset, driven out as a one-cycle pulse.
- A clear-all-active-interrupts command, also a one-cycle pulse.
- A system reset request to the outside world. This request is a level that stays high until the block's own reset input is asserted.

A local reset is itself a system reset. A write that sets the local reset bit therefore drops the outside request, even if the same write also sets the request bit.

Top module: `sysctl_keyreg`

## Requirements
- R1: A write whose bits 31:16 equal 0x05FA loads bits 10:8 into the priority-group field. The field reads back in bits 10:8 from the next cycle on.
- R2: A write whose bits 31:16 differ from 0x05FA has no effect at all: no field changes, no pulse and no request.
- R3: Bits 31:16 of the read data always show 0xFA05.
- R4: Bit 15 of the read data shows the byte order (1 = big endian). It is sampled from the byte-order input only while reset is asserted. Later changes of that input, and writes to bit 15, have no effect.
- R5: A cycle with reset asserted clears the priority-group field and the system reset request, and holds both pulse outputs low.
- R6: A keyed write with bit 2 set raises the system reset request from the next cycle on, and it reads back in bit 2. It stays high through later keyed writes that have bit 2 clear, until reset.
- R7: A keyed write with bit 1 set produces a clear-active pulse that is high for exactly the cycle after the write. Bit 1 always reads as 0.
- R8: A keyed write with bit 0 set produces a local-reset pulse that is high for exactly the cycle after the write. Bit 0 always reads as 0.
- R9: A keyed write with bit 0 set leaves the system reset request low from the next cycle on. This holds whatever bit 2 of that write is and whatever the request was before.
- R10: Bits 14:11 and 7:3 always read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the byte-order sampling window |
| big_endian_in | input | 1 | Byte-order strap, sampled during reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data, unlock value in bits 31:16 |
| rd_data | output | 32 | Current register view |
| local_reset_pulse | output | 1 | One-cycle local system reset |
| clear_active_pulse | output | 1 | One-cycle clear of all active-interrupt state |
| sysreset_req | output | 1 | Sticky system reset request |

## Verification
The state lives in the group field, the request flag, the byte-order latch and the two pulse registers, and all of them show at the ports on the cycle after the write that changes them. A write that gets past the key check when it should not shows at once: a group field or request changes on the next read, or a pulse appears where none is expected. A pulse register that fails to self-clear shows as an output high for two cycles. A byte-order latch that keeps tracking its input shows in bit 15 as soon as that input moves after reset. The collision case, where the local reset and the request bit are written together, shows in the request output one cycle after the write.

// File: rtl/sysctl_keyreg_pkg.sv
package sysctl_keyreg_pkg;
  // Bit positions that neighbouring logic decodes.
  localparam int unsigned POS_LOCRST  = 0;
  localparam int unsigned POS_CLRACT  = 1;
  localparam int unsigned POS_SYSREQ  = 2;
  localparam int unsigned POS_GRP_LO  = 8;
  localparam int unsigned POS_ENDIAN  = 15;

  // Index of each self-clearing action inside the pulse bank.
  localparam int unsigned PULSE_LOCRST = 0;
  localparam int unsigned PULSE_CLRACT = 1;
  localparam int unsigned NUM_PULSES   = 2;

  typedef struct packed {
    logic [2:0] grp;
    logic       sysreq;
    logic       endian;
  } ctl_state_t;
endpackage

// File: rtl/sysctl_key_gate.sv
module sysctl_key_gate #(
  parameter int unsigned       KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY    = 16'h05FA
) (
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  output logic             wr_accept
);
  always_comb begin
    wr_accept = wr_en && (wr_key == KEY);
  end
endmodule

// File: rtl/sysctl_pulse_bank.sv
module sysctl_pulse_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fire,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst) pulse[i] <= 1'b0;
      else     pulse[i] <= fire[i];
    end
  end
endmodule

// File: rtl/sysctl_state_regs.sv
module sysctl_state_regs
  import sysctl_keyreg_pkg::*;
#(
  parameter int unsigned GRP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             big_endian_in,
  input  logic             wr_accept,
  input  logic [GRP_W-1:0] wr_grp,
  input  logic             wr_sysreq,
  input  logic             wr_locrst,
  output logic [GRP_W-1:0] grp_q,
  output logic             sysreq_q,
  output logic             endian_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q    <= '0;
      sysreq_q <= 1'b0;
      endian_q <= big_endian_in;
    end else begin
      if (wr_accept) begin
        grp_q <= wr_grp;
        // A local reset drops the outside request, even when both are written together.
        if (wr_locrst)      sysreq_q <= 1'b0;
        else if (wr_sysreq) sysreq_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysctl_readback.sv
module sysctl_readback
  import sysctl_keyreg_pkg::*;
#(
  parameter int unsigned       DATA_W = 32,
  parameter int unsigned       KEY_W  = 16,
  parameter logic [KEY_W-1:0] SIG     = 16'hFA05,
  parameter int unsigned       GRP_W  = 3
) (
  input  logic [GRP_W-1:0]  grp_q,
  input  logic              sysreq_q,
  input  logic              endian_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned SIG_LO = DATA_W - KEY_W;

  always_comb begin
    rd_data                          = '0;
    rd_data[DATA_W-1:SIG_LO]         = SIG;
    rd_data[POS_ENDIAN]              = endian_q;
    rd_data[POS_GRP_LO +: GRP_W]     = grp_q;
    rd_data[POS_SYSREQ]              = sysreq_q;
  end
endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg
  import sysctl_keyreg_pkg::*;
#(
  parameter int unsigned       DATA_W = 32,
  parameter int unsigned       KEY_W  = 16,
  parameter logic [KEY_W-1:0] WR_KEY  = 16'h05FA,
  parameter logic [KEY_W-1:0] RD_SIG  = 16'hFA05,
  parameter int unsigned       GRP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_endian_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              local_reset_pulse,
  output logic              clear_active_pulse,
  output logic              sysreset_req
);
  localparam int unsigned KEY_LO = DATA_W - KEY_W;

  logic                  wr_accept;
  logic [GRP_W-1:0]      grp_q;
  logic                  sysreq_q;
  logic                  endian_q;
  logic [NUM_PULSES-1:0] fire;
  logic [NUM_PULSES-1:0] pulse;

  sysctl_key_gate #(.KEY_W(KEY_W), .KEY(WR_KEY)) u_gate (
    .wr_en     (wr_en),
    .wr_key    (wr_data[DATA_W-1:KEY_LO]),
    .wr_accept (wr_accept)
  );

  sysctl_state_regs #(.GRP_W(GRP_W)) u_state (
    .clk           (clk),
    .rst           (rst),
    .big_endian_in (big_endian_in),
    .wr_accept     (wr_accept),
    .wr_grp        (wr_data[POS_GRP_LO +: GRP_W]),
    .wr_sysreq     (wr_data[POS_SYSREQ]),
    .wr_locrst     (wr_data[POS_LOCRST]),
    .grp_q         (grp_q),
    .sysreq_q      (sysreq_q),
    .endian_q      (endian_q)
  );

  always_comb begin
    fire               = '0;
    fire[PULSE_LOCRST] = wr_accept && wr_data[POS_LOCRST];
    fire[PULSE_CLRACT] = wr_accept && wr_data[POS_CLRACT];
  end

  sysctl_pulse_bank #(.N(NUM_PULSES)) u_pulses (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .pulse (pulse)
  );

  sysctl_readback #(.DATA_W(DATA_W), .KEY_W(KEY_W), .SIG(RD_SIG), .GRP_W(GRP_W)) u_rd (
    .grp_q    (grp_q),
    .sysreq_q (sysreq_q),
    .endian_q (endian_q),
    .rd_data  (rd_data)
  );

  assign local_reset_pulse  = pulse[PULSE_LOCRST];
  assign clear_active_pulse = pulse[PULSE_CLRACT];
  assign sysreset_req       = sysreq_q;
endmodule

// File: rtl/sysctl_keyreg_checker.sv
module sysctl_keyreg_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [15:0] wr_key,
  input logic [2:0]  wr_grp,
  input logic [2:0]  wr_ctl,
  input logic [31:0] rd_data,
  input logic        local_reset_pulse,
  input logic        clear_active_pulse,
  input logic        sysreset_req
);
  logic keyed;
  assign keyed = wr_en && (wr_key == 16'h05FA);

  assert_grp_load_R1: assert property (@(posedge clk) disable iff (rst)
    keyed |=> rd_data[10:8] == $past(wr_grp));

  assert_badkey_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !keyed) |=> ($stable(rd_data) && !local_reset_pulse && !clear_active_pulse));

  assert_signature_R3: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:16] == 16'hFA05);

  assert_endian_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(rd_data[15]));

  assert_reset_clears_R5: assert property (@(posedge clk)
    rst |=> (!sysreset_req && !local_reset_pulse && !clear_active_pulse && rd_data[10:8] == 3'd0));

  assert_req_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_data[2] && !(keyed && wr_ctl[0])) |=> rd_data[2]);

  assert_clract_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    clear_active_pulse |-> $past(keyed && wr_ctl[1]));

  assert_locrst_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    local_reset_pulse |-> $past(keyed && wr_ctl[0]));

  assert_collision_R9: assert property (@(posedge clk) disable iff (rst)
    (keyed && wr_ctl[0]) |=> !sysreset_req);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_data[14:11] == 4'd0) && (rd_data[7:3] == 5'd0) && (rd_data[1:0] == 2'd0));
endmodule

bind sysctl_keyreg sysctl_keyreg_checker u_chk (
  .clk                (clk),
  .rst                (rst),
  .wr_en              (wr_en),
  .wr_key             (wr_data[31:16]),
  .wr_grp             (wr_data[10:8]),
  .wr_ctl             (wr_data[2:0]),
  .rd_data            (rd_data),
  .local_reset_pulse  (local_reset_pulse),
  .clear_active_pulse (clear_active_pulse),
  .sysreset_req       (sysreset_req)
);

// File: tb/test_sysctl_keyreg.sv
module test_sysctl_keyreg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian_in = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        local_reset_pulse;
  logic        clear_active_pulse;
  logic        sysreset_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_keyreg i_sysctl_keyreg (
    .clk                (clk),
    .rst                (rst),
    .big_endian_in      (big_endian_in),
    .wr_en              (wr_en),
    .wr_data            (wr_data),
    .rd_data            (rd_data),
    .local_reset_pulse  (local_reset_pulse),
    .clear_active_pulse (clear_active_pulse),
    .sysreset_req       (sysreset_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Sample point: the falling edge after the write edge.
  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic outs(input string req, input logic [31:0] rd, input logic lr, input logic ca, input logic sr);
    check(req, rd_data, rd);
    check(req, {29'd0, lr, ca, sr}, {29'd0, local_reset_pulse, clear_active_pulse, sysreset_req});
  endtask

  task automatic apply_reset(input logic be);
    @(negedge clk);
    rst = 1'b1; big_endian_in = be;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    apply_reset(1'b1);
    outs("R5/R3/R4 reset state", 32'hFA05_8000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_group_and_reserved;
    do_write(32'h05FA_0500);
    outs("R1 group=5", 32'hFA05_8500, 1'b0, 1'b0, 1'b0);
    do_write(32'h05FA_7FF8);
    outs("R1/R10 group=7 reserved ignored", 32'hFA05_8700, 1'b0, 1'b0, 1'b0);
    big_endian_in = 1'b0;
    do_write(32'h05FA_0700);
    outs("R4 endian input ignored after reset", 32'hFA05_8700, 1'b0, 1'b0, 1'b0);
    big_endian_in = 1'b1;
  endtask

  task automatic t_bad_key;
    do_write(32'h05FB_0207);
    outs("R2 wrong key ignored", 32'hFA05_8700, 1'b0, 1'b0, 1'b0);
    do_write(32'h0000_05FA);
    outs("R2 key in low half ignored", 32'hFA05_8700, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_clear_active;
    do_write(32'h05FA_0702);
    outs("R7 clear-active pulse, bit1 reads 0", 32'hFA05_8700, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    outs("R7 pulse self-clears", 32'hFA05_8700, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_local_reset;
    do_write(32'h05FA_0701);
    outs("R8 local-reset pulse, bit0 reads 0", 32'hFA05_8700, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    outs("R8 pulse self-clears", 32'hFA05_8700, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sysreq;
    do_write(32'h05FA_0704);
    outs("R6 request set", 32'hFA05_8704, 1'b0, 1'b0, 1'b1);
    do_write(32'h05FA_0300);
    outs("R6 request sticky across keyed write", 32'hFA05_8304, 1'b0, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    outs("R6 request held while idle", 32'hFA05_8304, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_collision;
    do_write(32'h05FA_0305);
    outs("R9 local reset drops held request", 32'hFA05_8300, 1'b1, 1'b0, 1'b0);
    do_write(32'h05FA_0305);
    outs("R9 both bits together leave request low", 32'hFA05_8300, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_rereset;
    do_write(32'h05FA_0604);
    outs("R6 request set before reset", 32'hFA05_8604, 1'b0, 1'b0, 1'b1);
    apply_reset(1'b0);
    outs("R5/R4 reset clears state and resamples endian", 32'hFA05_0000, 1'b0, 1'b0, 1'b0);
    do_write(32'h05FA_8000);
    outs("R4 write to bit15 ignored", 32'hFA05_0000, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_group_and_reserved();
    t_bad_key();
    t_clear_active();
    t_local_reset();
    t_sysreq();
    t_collision();
    t_rereset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule